// File: doc/BRIEF.md
# Switch Buffer Pool Admission Controller

This block owns the pool of frame buffer handles for a 12-port packet switch and decides, frame by frame, whether an arriving frame gets a buffer. Before traffic starts, software pushes every usable handle into the pool through a load interface. The supported pool sizes are 128, 256, 512 or 1024 handles. Each arriving frame presents an allocation request carrying its destination port and a multicast flag. One cycle later the block answers with either a granted handle or a discard. When a frame's buffer is freed, the handle comes back through a release interface together with the class that held it: an output port or the multicast class.

Occupancy is tracked per output port and for multicast traffic. Each count is compared against its own threshold, which is supplied on an input. A port whose count is above its threshold is blocked. Further unicast frames for that port are dropped, while frames for other ports still get buffers. This keeps one overloaded port from starving the whole switch. Multicast is blocked in the same way once its count reaches its limit, which leaves buffers for unicast traffic.

Top module: `buffer_admission`

## Requirements
- R1: After reset the pool is empty: `free_count` is 0, no port or multicast block bit is set, and an allocation request is answered with a discard.
- R2: Each cycle with `load_valid` high, and `rel_valid` low, appends `load_handle` to the pool. Granted handles leave the pool in the order they entered it (first in, first out).
- R3: Each cycle with `alloc_req` high produces, in the next cycle, exactly one of `rsp_grant` or `rsp_discard`. No response appears in any other cycle.
- R4: A request made while `free_count` is 0 is discarded.
- R5: A unicast grant adds one to the destination port's count, and a unicast release subtracts one (never below zero). Port p's threshold sits in `port_limit[p*11 +: 11]`. `port_blocked[p]` is high exactly while the count of port p is greater than that threshold.
- R6: A unicast request to a blocked port is discarded. Requests to unblocked ports are still granted while the pool has handles.
- R7: A multicast grant or release changes only the multicast count. `mc_blocked` is high while that count is at or above `mc_limit`. Multicast requests made then are discarded, while unicast requests are unaffected.
- R8: A released handle is appended to the pool tail and can be granted from the following cycle on. An allocation and a release in the same cycle both take effect.
- R9: `free_count` equals the number of handles in the pool. It never exceeds the pool capacity, and it drops by one for each grant.
- R10: A discarded request, including one whose `alloc_port` is 12 or more, changes neither the pool nor any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Push `load_handle` into the pool |
| load_handle | input | 10 | Handle written during initialisation |
| port_limit | input | 132 | Per-port thresholds, 11 bits per port, port 0 in the low bits |
| mc_limit | input | 11 | Multicast threshold |
| alloc_req | input | 1 | Allocation request |
| alloc_port | input | 4 | Destination port of the request |
| alloc_mc | input | 1 | Request belongs to the multicast class |
| rsp_grant | output | 1 | Request one cycle earlier was admitted |
| rsp_discard | output | 1 | Request one cycle earlier was dropped |
| rsp_handle | output | 10 | Granted handle, valid with `rsp_grant` |
| rel_valid | input | 1 | Return a handle to the pool |
| rel_handle | input | 10 | Handle being returned |
| rel_port | input | 4 | Port whose count is decremented |
| rel_mc | input | 1 | Returned handle belonged to the multicast class |
| free_count | output | 11 | Handles currently in the pool |
| port_blocked | output | 12 | Per-port blacklist flags |
| mc_blocked | output | 1 | Multicast blacklist flag |

## Verification
Some properties are checked on every cycle. Every request gets exactly one response one cycle later, and a request to an empty pool, a blocked port or a blocked multicast class always turns into a discard. A grant always lowers the free count by one, after allowing for a push in the same cycle, and a discard leaves it alone. Other behaviour can only be shown by the bench's scenarios. That covers which exact handle comes out, the first-in first-out order across loads and releases, and the exact point where a port crosses its threshold and later recovers. It also covers an allocation and a release colliding in one cycle, and a handle reappearing right after the pool ran dry.

// File: rtl/bufadm_pkg.sv
package bufadm_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE    = 2'd0,
    RSP_GRANT   = 2'd1,
    RSP_DISCARD = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/handle_fifo.sv
module handle_fifo #(
  parameter int unsigned HANDLE_W = 10,
  parameter int unsigned DEPTH    = 1024,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned CW      = AW + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic [HANDLE_W-1:0] push_data,
  input  logic                pop,
  output logic [HANDLE_W-1:0] pop_data,
  output logic [CW-1:0]       count
);
  logic [HANDLE_W-1:0] mem [DEPTH];
  logic [AW-1:0]       wr_ptr, rd_ptr;
  logic                push_ok, pop_ok;

  assign pop_ok  = pop && (count != '0);
  assign push_ok = push && ((count != CW'(DEPTH)) || pop_ok);

  // storage without reset so it maps onto block RAM with a registered read
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
    if (pop_ok)  pop_data    <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/occupancy_counters.sv
module occupancy_counters #(
  parameter int unsigned NUM_PORTS = 12,
  parameter int unsigned CNT_W     = 11,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inc_en,
  input  logic                       inc_mc,
  input  logic [PORT_W-1:0]          inc_port,
  input  logic                       dec_en,
  input  logic                       dec_mc,
  input  logic [PORT_W-1:0]          dec_port,
  input  logic [NUM_PORTS*CNT_W-1:0] port_limit,
  input  logic [CNT_W-1:0]           mc_limit,
  output logic [NUM_PORTS-1:0]       port_block,
  output logic                       mc_block
);
  logic [CNT_W-1:0] mc_cnt;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [CNT_W-1:0] cnt;
    logic             up, down;
    assign up   = inc_en && !inc_mc && (inc_port == PORT_W'(p));
    assign down = dec_en && !dec_mc && (dec_port == PORT_W'(p));
    always_ff @(posedge clk) begin
      if (rst)                          cnt <= '0;
      else if (up && !down)             cnt <= cnt + 1'b1;
      else if (down && !up && cnt != 0) cnt <= cnt - 1'b1;
    end
    assign port_block[p] = cnt > port_limit[p*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) mc_cnt <= '0;
    else if (inc_en && inc_mc && !(dec_en && dec_mc)) mc_cnt <= mc_cnt + 1'b1;
    else if (dec_en && dec_mc && !(inc_en && inc_mc) && mc_cnt != 0)
      mc_cnt <= mc_cnt - 1'b1;
  end

  assign mc_block = mc_cnt >= mc_limit;
endmodule

// File: rtl/buffer_admission.sv
module buffer_admission
  import bufadm_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 12,
  parameter int unsigned HANDLE_W   = 10,
  parameter int unsigned POOL_DEPTH = 1024,
  localparam int unsigned PORT_W    = $clog2(NUM_PORTS),
  localparam int unsigned CNT_W     = HANDLE_W + 1,
  localparam int unsigned FREE_W    = $clog2(POOL_DEPTH) + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_valid,
  input  logic [HANDLE_W-1:0]        load_handle,
  input  logic [NUM_PORTS*CNT_W-1:0] port_limit,
  input  logic [CNT_W-1:0]           mc_limit,
  input  logic                       alloc_req,
  input  logic [PORT_W-1:0]          alloc_port,
  input  logic                       alloc_mc,
  output logic                       rsp_grant,
  output logic                       rsp_discard,
  output logic [HANDLE_W-1:0]        rsp_handle,
  input  logic                       rel_valid,
  input  logic [HANDLE_W-1:0]        rel_handle,
  input  logic [PORT_W-1:0]          rel_port,
  input  logic                       rel_mc,
  output logic [FREE_W-1:0]          free_count,
  output logic [NUM_PORTS-1:0]       port_blocked,
  output logic                       mc_blocked
);
  rsp_kind_e           rsp_q;
  logic                in_range, class_ok, admit;
  logic                push_any;
  logic [HANDLE_W-1:0] push_val;

  assign in_range = {1'b0, alloc_port} < (PORT_W+1)'(NUM_PORTS);
  assign class_ok = alloc_mc ? !mc_blocked
                             : (in_range && !port_blocked[alloc_port]);
  assign admit    = alloc_req && (free_count != '0) && class_ok;

  // a release wins the single write slot over an initialisation load
  assign push_any = rel_valid || load_valid;
  assign push_val = rel_valid ? rel_handle : load_handle;

  handle_fifo #(
    .HANDLE_W (HANDLE_W),
    .DEPTH    (POOL_DEPTH)
  ) u_pool (
    .clk       (clk),
    .rst       (rst),
    .push      (push_any),
    .push_data (push_val),
    .pop       (admit),
    .pop_data  (rsp_handle),
    .count     (free_count)
  );

  occupancy_counters #(
    .NUM_PORTS (NUM_PORTS),
    .CNT_W     (CNT_W)
  ) u_occ (
    .clk        (clk),
    .rst        (rst),
    .inc_en     (admit),
    .inc_mc     (alloc_mc),
    .inc_port   (alloc_port),
    .dec_en     (rel_valid),
    .dec_mc     (rel_mc),
    .dec_port   (rel_port),
    .port_limit (port_limit),
    .mc_limit   (mc_limit),
    .port_block (port_blocked),
    .mc_block   (mc_blocked)
  );

  always_ff @(posedge clk) begin
    if (rst)            rsp_q <= RSP_IDLE;
    else if (admit)     rsp_q <= RSP_GRANT;
    else if (alloc_req) rsp_q <= RSP_DISCARD;
    else                rsp_q <= RSP_IDLE;
  end

  assign rsp_grant   = (rsp_q == RSP_GRANT);
  assign rsp_discard = (rsp_q == RSP_DISCARD);
endmodule

// File: rtl/buffer_admission_checker.sv
module buffer_admission_checker #(
  parameter int unsigned NUM_PORTS  = 12,
  parameter int unsigned POOL_DEPTH = 1024,
  localparam int unsigned PORT_W    = $clog2(NUM_PORTS),
  localparam int unsigned FREE_W    = $clog2(POOL_DEPTH) + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 load_valid,
  input logic                 alloc_req,
  input logic [PORT_W-1:0]    alloc_port,
  input logic                 alloc_mc,
  input logic                 rsp_grant,
  input logic                 rsp_discard,
  input logic                 rel_valid,
  input logic [FREE_W-1:0]    free_count,
  input logic [NUM_PORTS-1:0] port_blocked,
  input logic                 mc_blocked
);
  logic pushing, port_req_blocked;
  assign pushing = rel_valid || load_valid;
  assign port_req_blocked = ({1'b0, alloc_port} < (PORT_W+1)'(NUM_PORTS))
                            && port_blocked[alloc_port];

  p_single_rsp_r3: assert property (@(posedge clk) disable iff (rst)
    !(rsp_grant && rsp_discard));
  p_rsp_has_req_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_grant || rsp_discard) |-> $past(alloc_req));
  p_req_answered_r3: assert property (@(posedge clk) disable iff (rst)
    alloc_req |=> (rsp_grant || rsp_discard));
  p_empty_discard_r4: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && free_count == '0) |=> rsp_discard);
  p_port_block_r6: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && !alloc_mc && port_req_blocked) |=> rsp_discard);
  p_mc_block_r7: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && alloc_mc && mc_blocked) |=> rsp_discard);
  p_free_bound_r9: assert property (@(posedge clk) disable iff (rst)
    free_count <= FREE_W'(POOL_DEPTH));
  p_grant_pops_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_grant |-> (int'(free_count) + 1 ==
                   int'($past(free_count)) + int'($past(pushing))));
  p_discard_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_discard && !$past(pushing)) |-> free_count == $past(free_count));
endmodule

bind buffer_admission buffer_admission_checker #(
  .NUM_PORTS  (NUM_PORTS),
  .POOL_DEPTH (POOL_DEPTH)
) u_checker (
  .clk          (clk),
  .rst          (rst),
  .load_valid   (load_valid),
  .alloc_req    (alloc_req),
  .alloc_port   (alloc_port),
  .alloc_mc     (alloc_mc),
  .rsp_grant    (rsp_grant),
  .rsp_discard  (rsp_discard),
  .rel_valid    (rel_valid),
  .free_count   (free_count),
  .port_blocked (port_blocked),
  .mc_blocked   (mc_blocked)
);

// File: tb/test_buffer_admission.sv
module test_buffer_admission;
  localparam int NP = 12, HW = 10, DEPTH = 1024, PW = 4, CW = 11, FW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic             load_valid = 0, alloc_req = 0, alloc_mc = 0, rel_valid = 0, rel_mc = 0;
  logic [HW-1:0]    load_handle = '0, rel_handle = '0, rsp_handle;
  logic [PW-1:0]    alloc_port = '0, rel_port = '0;
  logic [NP*CW-1:0] port_limit = '0;
  logic [CW-1:0]    mc_limit = '0;
  logic             rsp_grant, rsp_discard, mc_blocked;
  logic [FW-1:0]    free_count;
  logic [NP-1:0]    port_blocked;

  buffer_admission i_buffer_admission (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_handle(load_handle),
    .port_limit(port_limit), .mc_limit(mc_limit), .alloc_req(alloc_req),
    .alloc_port(alloc_port), .alloc_mc(alloc_mc), .rsp_grant(rsp_grant),
    .rsp_discard(rsp_discard), .rsp_handle(rsp_handle), .rel_valid(rel_valid),
    .rel_handle(rel_handle), .rel_port(rel_port), .rel_mc(rel_mc),
    .free_count(free_count), .port_blocked(port_blocked), .mc_blocked(mc_blocked));

  int checks = 0, errors = 0;
  bit finished = 0;
  int port_cnt[NP];
  int mc_cnt = 0;
  int pool_q[$];
  int port_thr[NP];
  int mc_thr = 100;
  bit    exp_grant[$];
  int    exp_handle[$];
  string exp_tag[$];

  task automatic report_fail(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  task automatic drive_limits();
    for (int p = 0; p < NP; p++) port_limit[p*CW +: CW] = CW'(port_thr[p]);
    mc_limit = CW'(mc_thr);
  endtask

  // driver: one call per clock cycle; pushes the expected response
  task automatic cyc(bit a, int ap, bit amc, bit r, int rh, int rp, bit rmc,
                     bit l, int lh, string tag);
    bit admit;
    @(posedge clk); #1;
    alloc_req = a; alloc_port = PW'(ap); alloc_mc = amc;
    rel_valid = r; rel_handle = HW'(rh); rel_port = PW'(rp); rel_mc = rmc;
    load_valid = l; load_handle = HW'(lh);
    drive_limits();
    if (a) begin
      admit = pool_q.size() > 0 &&
              (amc ? (mc_cnt < mc_thr) : (ap < NP && port_cnt[ap] <= port_thr[ap]));
      exp_grant.push_back(admit);
      exp_tag.push_back(tag);
      if (admit) begin
        exp_handle.push_back(pool_q.pop_front());
        if (amc) mc_cnt++; else port_cnt[ap]++;
      end else exp_handle.push_back(-1);
    end
    if (r) begin
      if (pool_q.size() < DEPTH) pool_q.push_back(rh);
      if (rmc) begin if (mc_cnt > 0) mc_cnt--; end
      else if (rp < NP && port_cnt[rp] > 0) port_cnt[rp]--;
    end else if (l && pool_q.size() < DEPTH) pool_q.push_back(lh);
  endtask

  task automatic idle();                         cyc(0,0,0,0,0,0,0,0,0,""); endtask
  task automatic alloc(int p, bit mc, string t); cyc(1,p,mc,0,0,0,0,0,0,t); endtask
  task automatic rel(int h, int p, bit mc);      cyc(0,0,0,1,h,p,mc,0,0,""); endtask

  task automatic check_status(string tag);
    logic [NP-1:0] eb;
    idle();
    @(negedge clk);
    for (int p = 0; p < NP; p++) eb[p] = port_cnt[p] > port_thr[p];
    checks++;
    if (free_count !== FW'(pool_q.size()))
      report_fail(tag, "free_count", int'(free_count), pool_q.size());
    checks++;
    if (port_blocked !== eb)
      report_fail(tag, "port_blocked", int'(port_blocked), int'(eb));
    checks++;
    if (mc_blocked !== (mc_cnt >= mc_thr))
      report_fail(tag, "mc_blocked", int'(mc_blocked), int'(mc_cnt >= mc_thr));
  endtask

  // monitor: pops the scoreboard whenever a response appears
  always @(negedge clk) begin
    if (!rst && !finished && (rsp_grant || rsp_discard)) begin
      checks++;
      if (exp_grant.size() == 0) begin
        report_fail("R3", "unexpected response", 1, 0);
      end else begin
        automatic bit    eg = exp_grant.pop_front();
        automatic int    eh = exp_handle.pop_front();
        automatic string et = exp_tag.pop_front();
        if (rsp_grant && rsp_discard)
          report_fail({et, "/R3"}, "grant and discard together", 1, 0);
        else if (rsp_grant !== eg)
          report_fail(et, "rsp_grant", int'(rsp_grant), int'(eg));
        else if (eg && int'(rsp_handle) != eh)
          report_fail(et, "rsp_handle", int'(rsp_handle), eh);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin port_thr[p] = 200; port_cnt[p] = 0; end
    drive_limits();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (free_count !== '0) report_fail("R1", "free_count after reset", int'(free_count), 0);
    checks++;
    if (port_blocked !== '0 || mc_blocked !== 1'b0)
      report_fail("R1", "block flags after reset", int'({mc_blocked, port_blocked}), 0);
    alloc(0, 0, "R1_R4 empty pool");
    check_status("R1");

    for (int h = 0; h < 128; h++) cyc(0,0,0,0,0,0,0,1,h,"");
    check_status("R2_R9 after load");

    port_thr[2] = 3; mc_thr = 2;
    for (int i = 0; i < 4; i++) alloc(2, 0, "R2_R5 fifo order");
    check_status("R5 port2 over threshold");
    alloc(2, 0, "R6 blocked port");
    alloc(5, 0, "R6 other port admitted");
    rel(0, 2, 0);
    check_status("R5 port2 recovered");
    alloc(2, 0, "R5 admitted after release");

    for (int i = 0; i < 3; i++) alloc(0, 1, "R7 multicast limit");
    check_status("R7 mc blocked");
    alloc(7, 0, "R7 unicast unaffected");
    cyc(1,0,1,1,6,0,1,0,0,"R7_R8 mc alloc with release");
    alloc(0, 1, "R7 mc after release");
    alloc(13, 0, "R10 port out of range");
    cyc(1,3,0,1,1,2,0,0,0,"R8 alloc with release");
    check_status("R10_R8 state");

    for (int p = 0; p < NP; p++) port_thr[p] = 200;
    mc_thr = 200;
    while (pool_q.size() > 0) alloc(pool_q.size() % NP, 0, "R9 draining");
    alloc(4, 0, "R4 exhausted");
    check_status("R4_R9 empty");
    cyc(1,1,0,1,9,1,0,0,0,"R8 release into empty pool");
    alloc(1, 0, "R8 released handle reused");
    rel(0, 0, 0);
    alloc(0, 0, "R8 reuse next cycle");
    check_status("R9 final");
    repeat (3) idle();
    @(negedge clk);
    checks++;
    if (exp_grant.size() != 0)
      report_fail("R3", "missing responses", 0, exp_grant.size());

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule